// File: doc/BRIEF.md
# Serial Port Receiver with Per-Byte Error Flags

This block is the receive side of a memory-mapped serial port. It samples the incoming line with a tick that runs at sixteen times the bit rate. It finds each frame's start bit and collects eight data bits, least significant first. It then checks an optional even or odd parity bit and the first stop bit. Each finished byte goes into an eight-entry FIFO, and the parity and framing results are stored with that byte.

Software uses four word registers: mode, status, receive data and bit-rate divisor. The status register reports these conditions:
- a byte is waiting;
- a sticky overrun;
- the parity and framing results for the byte at the FIFO head;
- whether a frame is being received at the moment.

A level interrupt request follows a programmable FIFO fill condition. A loopback bit takes the receiver input from the transmitter's serial output instead of the pin. After an overrun the receiver accepts no more bytes until software clears the overrun flag. Clearing that flag also empties the FIFO.

Top module: `rxport`

## Requirements
- R1: After reset the status register (address 1) reads 0x0010, the mode register (address 0) reads 0x0000 and `rx_irq` is 0.
- R2: With mode bit 15 (on) and status bit 12 (receive enable) both set, a frame is decoded as one low start bit, then 8 data bits least significant first, then a stop bit. The byte is read from bits 7:0 of address 2, and bits 15:8 read 0. Status bit 0 is 1 while at least one byte is waiting.
- R3: The FIFO holds 8 bytes. Reads of address 2 return them in arrival order, and each read removes one byte. Status bit 0 returns to 0 once the last byte is read.
- R4: Mode bits 2:1 select parity: 00 means none, 01 means even, 10 means odd, and 11 means none. With parity on, a ninth bit follows the data. Status bit 3 shows the parity error stored with the byte at the FIFO head.
- R5: A first stop bit that samples low marks that byte with a framing error, shown in status bit 2 while it is at the head. Both error bits move to the next byte's values when the head is read.
- R6: A byte that completes while the FIFO is full sets the sticky overrun flag (status bit 1) and is dropped. While that flag is set, every further byte is dropped. A status write with bit 1 at 0 clears the flag and empties the FIFO.
- R7: Status bits 7:6 select when `rx_irq` is high: 00 or 01 means any byte is waiting, 10 means 6 or more bytes are waiting, and 11 means the FIFO is full.
- R8: With mode bit 6 set, the receiver listens to `tx_loop` and ignores `rx_pin`. With mode bit 6 clear, it listens to `rx_pin` and ignores `tx_loop`.
- R9: Status bit 4 reads 1 when no frame is in progress and 0 from start-bit detection until the stop bit has been sampled.
- R10: A start needs a high-to-low transition on the line. The line must still be low 8 ticks later. A low pulse shorter than half a bit is rejected and stores nothing.
- R11: If mode bit 15 or status bit 12 is clear, the line is ignored and no byte is stored.
- R12: Address 3 holds a divisor D. One tick occurs every D+1 clocks, so a bit lasts 16*(D+1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | 2 | Word address: 0 mode, 1 status, 2 receive data, 3 divisor |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid while reg_sel is high |
| rx_pin | input | 1 | Serial input pin, idle high |
| tx_loop | input | 1 | Transmitter serial output, used in loopback |
| rx_irq | output | 1 | Receive interrupt request (level) |

## Verification
Each defect shows up at the ports in its own way:
- A wrong tick or bit count in the deframer corrupts the bytes read from address 2, or loses them. This becomes visible on the first read after the frame.
- A FIFO pointer or count error appears as out-of-order data. It can also appear as a data-available bit that stays set or clears early once the queue is drained.
- Error flags filed against the wrong entry show up as parity or framing bits that do not advance with the head read.
- A receiver that does not freeze after overrun leaves extra bytes to read, which a drain after the overrun exposes.

The sweep of all 256 byte values, with rotating parity modes, covers every data-bit position and both parity senses.

// File: rtl/rxport_pkg.sv
package rxport_pkg;
  localparam int STA_RXEN    = 12;
  localparam int STA_ISEL_HI = 7;
  localparam int STA_ISEL_LO = 6;
  localparam int STA_IDLE    = 4;
  localparam int STA_PERR    = 3;
  localparam int STA_FERR    = 2;
  localparam int STA_OERR    = 1;
  localparam int STA_DAV     = 0;

  localparam int MODE_ON     = 15;
  localparam int MODE_LOOP   = 6;
  localparam int MODE_PAR_HI = 2;
  localparam int MODE_PAR_LO = 1;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_DIV  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic       perr;
    logic       ferr;
    logic [7:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rxport_baud.sv
module rxport_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_n;

  assign tick = en && (cnt_q == div);

  always_comb begin
    cnt_n = cnt_q;
    if (!en || tick) cnt_n = '0;
    else             cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // the tick period is set by the divisor (R12)
  p_tick_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick);
endmodule

// File: rtl/rxport_deframe.sv
module rxport_deframe
  import rxport_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              line_raw,
  input  logic [1:0]        par_mode,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              perr,
  output logic              ferr,
  output logic              idle
);
  localparam int TW  = $clog2(OVS);
  localparam int BW  = $clog2(DATA_W);
  localparam int MID = OVS / 2 - 1;

  logic sync1_q, sync2_q, prev_q;
  logic line, fall;
  rx_state_e state_q, state_n;
  logic [TW-1:0]     tcnt_q, tcnt_n;
  logic [BW-1:0]     bcnt_q, bcnt_n;
  logic [DATA_W-1:0] shr_q, shr_n;
  logic              perr_q, perr_n;
  logic              par_en, par_odd, last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      prev_q  <= 1'b1;
    end else begin
      sync1_q <= line_raw;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign line      = sync2_q;
  assign fall      = prev_q && !line;
  assign par_en    = (par_mode == 2'b01) || (par_mode == 2'b10);
  assign par_odd   = (par_mode == 2'b10);
  assign last_tick = tick && (tcnt_q == TW'(OVS - 1));

  always_comb begin
    state_n = state_q;
    tcnt_n  = tcnt_q;
    bcnt_n  = bcnt_q;
    shr_n   = shr_q;
    perr_n  = perr_q;
    done    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (fall) begin
          state_n = ST_START;
          tcnt_n  = '0;
          perr_n  = 1'b0;
        end
      end
      ST_START: begin
        if (tick) begin
          if (tcnt_q == TW'(MID)) begin
            state_n = line ? ST_IDLE : ST_DATA;
            tcnt_n  = '0;
            bcnt_n  = '0;
          end else begin
            tcnt_n = tcnt_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (last_tick) begin
          shr_n  = {line, shr_q[DATA_W-1:1]};
          tcnt_n = '0;
          if (bcnt_q == BW'(DATA_W - 1)) state_n = par_en ? ST_PAR : ST_STOP;
          else                           bcnt_n  = bcnt_q + 1'b1;
        end else if (tick) begin
          tcnt_n = tcnt_q + 1'b1;
        end
      end
      ST_PAR: begin
        if (last_tick) begin
          perr_n  = par_odd ? ~(^{shr_q, line}) : (^{shr_q, line});
          state_n = ST_STOP;
          tcnt_n  = '0;
        end else if (tick) begin
          tcnt_n = tcnt_q + 1'b1;
        end
      end
      ST_STOP: begin
        if (last_tick) begin
          done    = 1'b1;
          state_n = ST_IDLE;
          tcnt_n  = '0;
        end else if (tick) begin
          tcnt_n = tcnt_q + 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
    if (!en) begin
      state_n = ST_IDLE;
      done    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      shr_q   <= '0;
      perr_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      tcnt_q  <= tcnt_n;
      bcnt_q  <= bcnt_n;
      shr_q   <= shr_n;
      perr_q  <= perr_n;
    end
  end

  assign data = shr_q;
  assign perr = perr_q;
  assign ferr = ~line;
  assign idle = (state_q == ST_IDLE);

  // a disabled receiver is idle on the next cycle (R11)
  p_idle_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> idle);
  // a completed frame returns to idle (R9)
  p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> idle);
endmodule

// File: rtl/rxport_fifo.sv
module rxport_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_n, rptr_q, rptr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && (!full || pop);
  assign do_pop  = pop && !empty;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    cnt_n  = cnt_q;
    if (flush) begin
      wptr_n = '0;
      rptr_n = '0;
      cnt_n  = '0;
    end else begin
      if (do_push) wptr_n = bump(wptr_q);
      if (do_pop)  rptr_n = bump(rptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_n = cnt_q + 1'b1;
        2'b01:   cnt_n = cnt_q - 1'b1;
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wptr_q] <= wdata;
  end

  assign rdata = mem[rptr_q];
  assign count = cnt_q;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_full_push_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> full);
  p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/rxport.sv
module rxport
  import rxport_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        rx_pin,
  input  logic        tx_loop,
  output logic        rx_irq
);
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int THRESH = (DEPTH * 3) / 4;
  localparam int EW     = $bits(rx_entry_t);

  logic       on_q, on_n, loop_q, loop_n, rxen_q, rxen_n, oerr_q, oerr_n;
  logic [1:0] par_q, par_n, isel_q, isel_n;
  logic [DIV_W-1:0] div_q, div_n;

  logic wr_mode, wr_stat, wr_div, rd_data;
  logic en, tick, line_raw;
  logic fr_done, fr_perr, fr_ferr, fr_idle;
  logic [7:0] fr_data;
  logic push, pop, clr_ovr;
  rx_entry_t in_ent, head;
  logic [EW-1:0] head_bits;
  logic [CW-1:0] count;
  logic full, empty;

  assign wr_mode = reg_sel && reg_wr && (reg_addr == ADDR_MODE);
  assign wr_stat = reg_sel && reg_wr && (reg_addr == ADDR_STAT);
  assign wr_div  = reg_sel && reg_wr && (reg_addr == ADDR_DIV);
  assign rd_data = reg_sel && !reg_wr && (reg_addr == ADDR_DATA);

  assign en       = on_q && rxen_q;
  assign line_raw = loop_q ? tx_loop : rx_pin;
  assign clr_ovr  = wr_stat && !reg_wdata[STA_OERR] && oerr_q;
  assign pop      = rd_data && !empty;
  assign push     = fr_done && !oerr_q && (!full || pop);

  always_comb begin
    on_n   = on_q;
    loop_n = loop_q;
    par_n  = par_q;
    rxen_n = rxen_q;
    isel_n = isel_q;
    div_n  = div_q;
    oerr_n = oerr_q;
    if (wr_mode) begin
      on_n   = reg_wdata[MODE_ON];
      loop_n = reg_wdata[MODE_LOOP];
      par_n  = reg_wdata[MODE_PAR_HI:MODE_PAR_LO];
    end
    if (wr_stat) begin
      rxen_n = reg_wdata[STA_RXEN];
      isel_n = reg_wdata[STA_ISEL_HI:STA_ISEL_LO];
    end
    if (wr_div) div_n = reg_wdata[DIV_W-1:0];
    if (clr_ovr)                                  oerr_n = 1'b0;
    else if (fr_done && !oerr_q && full && !pop)  oerr_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      loop_q <= 1'b0;
      par_q  <= 2'b00;
      rxen_q <= 1'b0;
      isel_q <= 2'b00;
      div_q  <= '0;
      oerr_q <= 1'b0;
    end else begin
      on_q   <= on_n;
      loop_q <= loop_n;
      par_q  <= par_n;
      rxen_q <= rxen_n;
      isel_q <= isel_n;
      div_q  <= div_n;
      oerr_q <= oerr_n;
    end
  end

  rxport_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .en(en), .div(div_q), .tick(tick)
  );

  rxport_deframe #(.OVS(16), .DATA_W(8)) u_deframe (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .line_raw(line_raw),
    .par_mode(par_q), .done(fr_done), .data(fr_data), .perr(fr_perr),
    .ferr(fr_ferr), .idle(fr_idle)
  );

  assign in_ent = '{perr: fr_perr, ferr: fr_ferr, data: fr_data};

  rxport_fifo #(.DEPTH(DEPTH), .WIDTH(EW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(clr_ovr),
    .wdata(in_ent), .rdata(head_bits), .count(count), .full(full), .empty(empty)
  );

  assign head = rx_entry_t'(head_bits);

  always_comb begin
    case (isel_q)
      2'b10:   rx_irq = (count >= CW'(THRESH));
      2'b11:   rx_irq = full;
      default: rx_irq = !empty;
    endcase
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_MODE: begin
        reg_rdata[MODE_ON]                 = on_q;
        reg_rdata[MODE_LOOP]               = loop_q;
        reg_rdata[MODE_PAR_HI:MODE_PAR_LO] = par_q;
      end
      ADDR_STAT: begin
        reg_rdata[STA_RXEN]                = rxen_q;
        reg_rdata[STA_ISEL_HI:STA_ISEL_LO] = isel_q;
        reg_rdata[STA_IDLE]                = fr_idle;
        reg_rdata[STA_PERR]                = head.perr && !empty;
        reg_rdata[STA_FERR]                = head.ferr && !empty;
        reg_rdata[STA_OERR]                = oerr_q;
        reg_rdata[STA_DAV]                 = !empty;
      end
      ADDR_DATA: if (!empty) reg_rdata[7:0] = head.data;
      default:   reg_rdata = 16'(div_q);
    endcase
  end

  p_oerr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (oerr_q && !clr_ovr) |=> oerr_q);
  p_frozen_no_growth_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (oerr_q && !clr_ovr && !pop) |=> $stable(count));
  p_irq_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (isel_q[1] == 1'b0) |-> (rx_irq == (count != '0)));
endmodule

// File: tb/rxport_tb.sv
module rxport_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        reg_sel, reg_wr;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        rx_pin, tx_loop, rx_irq;

  int nchk = 0;
  int nerr = 0;
  int bp   = 16;
  bit finished = 0;

  rxport u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_pin(rx_pin), .tx_loop(tx_loop), .rx_irq(rx_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #(CLK_PERIOD / 4);
    d = reg_rdata;
    @(negedge clk);
    reg_sel = 1'b0;
  endtask

  task automatic drive_bit(input logic v, input bit lp);
    if (lp) tx_loop = v; else rx_pin = v;
    repeat (bp) @(negedge clk);
  endtask

  // pm: 0 none, 1 even, 2 odd
  task automatic send(input logic [7:0] b, input int pm, input bit flip,
                      input bit stopv, input bit lp);
    logic p;
    drive_bit(1'b0, lp);
    for (int i = 0; i < 8; i++) drive_bit(b[i], lp);
    if (pm != 0) begin
      p = (pm == 1) ? ^b : ~(^b);
      drive_bit(p ^ flip, lp);
    end
    drive_bit(stopv, lp);
    if (lp) tx_loop = 1'b1; else rx_pin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_byte(input logic [7:0] b, input string req);
    logic [15:0] d;
    bus_rd(2'd2, d);
    chk(d == {8'h00, b}, req, d, {8'h00, b});
  endtask

  task automatic expect_stat(input logic [15:0] mask, input logic [15:0] val,
                             input string req);
    logic [15:0] d;
    bus_rd(2'd1, d);
    chk((d & mask) == val, req, d & mask, val);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    rx_pin = 1'b1; tx_loop = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(2'd1, d); chk(d == 16'h0010, "R1 status", d, 16'h0010);
    bus_rd(2'd0, d); chk(d == 16'h0000, "R1 mode", d, 0);
    chk(rx_irq == 1'b0, "R1 irq", rx_irq, 0);

    bus_wr(2'd0, 16'h8000);
    bus_wr(2'd1, 16'h1000);

    // R2 / R4 sweep over all byte values, rotating parity modes
    for (int b = 0; b < 256; b++) begin
      int pm;
      bit bad;
      pm  = b % 3;
      bad = (b % 16 == 5) && (pm != 0);
      bus_wr(2'd0, 16'h8000 | 16'(pm << 1));
      send(8'(b), pm, bad, 1'b1, 1'b0);
      expect_stat(16'h000F, bad ? 16'h0009 : 16'h0001, "R4 perr/R2 dav sweep");
      expect_byte(8'(b), "R2 data sweep");
    end
    bus_wr(2'd0, 16'h8000);
    expect_stat(16'h0001, 16'h0000, "R2 dav clear");

    // R3 order through full FIFO
    for (int i = 0; i < 8; i++) send(8'h30 + 8'(i), 0, 0, 1, 0);
    expect_stat(16'h0003, 16'h0001, "R3 full no overrun");
    for (int i = 0; i < 8; i++) expect_byte(8'h30 + 8'(i), "R3 order");
    expect_stat(16'h0001, 16'h0000, "R3 empty");

    // R7 interrupt thresholds
    bus_wr(2'd1, 16'h1080);
    for (int i = 0; i < 5; i++) send(8'h40 + 8'(i), 0, 0, 1, 0);
    #1 chk(rx_irq == 1'b0, "R7 sel10 five", rx_irq, 0);
    send(8'h45, 0, 0, 1, 0);
    #1 chk(rx_irq == 1'b1, "R7 sel10 six", rx_irq, 1);
    bus_wr(2'd1, 16'h10C0);
    #1 chk(rx_irq == 1'b0, "R7 sel11 six", rx_irq, 0);
    send(8'h46, 0, 0, 1, 0);
    #1 chk(rx_irq == 1'b0, "R7 sel11 seven", rx_irq, 0);
    send(8'h47, 0, 0, 1, 0);
    #1 chk(rx_irq == 1'b1, "R7 sel11 full", rx_irq, 1);
    bus_wr(2'd1, 16'h1000);
    #1 chk(rx_irq == 1'b1, "R7 sel00 any", rx_irq, 1);
    for (int i = 0; i < 8; i++) expect_byte(8'h40 + 8'(i), "R7 drain");
    #1 chk(rx_irq == 1'b0, "R7 sel00 empty", rx_irq, 0);

    // R6 overrun: drop and freeze
    for (int i = 0; i < 9; i++) send(8'h50 + 8'(i), 0, 0, 1, 0);
    expect_stat(16'h0003, 16'h0003, "R6 overrun set");
    send(8'h6A, 0, 0, 1, 0);
    for (int i = 0; i < 8; i++) expect_byte(8'h50 + 8'(i), "R6 kept first eight");
    expect_stat(16'h0003, 16'h0002, "R6 frozen dropped");
    send(8'h6B, 0, 0, 1, 0);
    expect_stat(16'h0003, 16'h0002, "R6 still frozen");
    bus_wr(2'd1, 16'h1002);
    expect_stat(16'h0002, 16'h0002, "R6 write one keeps flag");
    // R6 clear flushes
    bus_wr(2'd1, 16'h1000);
    expect_stat(16'h0003, 16'h0000, "R6 cleared");
    for (int i = 0; i < 9; i++) send(8'h70 + 8'(i), 0, 0, 1, 0);
    bus_wr(2'd1, 16'h1000);
    expect_stat(16'h0003, 16'h0000, "R6 clear flushes");
    send(8'h5A, 0, 0, 1, 0);
    expect_byte(8'h5A, "R6 resumes");

    // R5 framing per entry
    send(8'h11, 0, 0, 0, 0);
    send(8'h22, 0, 0, 1, 0);
    expect_stat(16'h0005, 16'h0005, "R5 ferr head");
    expect_byte(8'h11, "R5 bad-stop data");
    expect_stat(16'h0005, 16'h0001, "R5 ferr advances");
    expect_byte(8'h22, "R5 next data");

    // R4 parity per entry
    bus_wr(2'd0, 16'h8002);
    send(8'h44, 1, 0, 1, 0);
    send(8'h45, 1, 1, 1, 0);
    expect_stat(16'h0009, 16'h0001, "R4 good head");
    expect_byte(8'h44, "R4 data");
    expect_stat(16'h0009, 16'h0009, "R4 perr advances");
    expect_byte(8'h45, "R4 data bad");
    bus_wr(2'd0, 16'h8006);
    send(8'hC3, 0, 0, 1, 0);
    expect_stat(16'h0009, 16'h0001, "R4 mode11 none");
    expect_byte(8'hC3, "R4 mode11 data");
    bus_wr(2'd0, 16'h8000);

    // R8 loopback
    bus_wr(2'd0, 16'h8040);
    rx_pin = 1'b0;
    send(8'h9C, 0, 0, 1, 1);
    rx_pin = 1'b1;
    expect_byte(8'h9C, "R8 loopback data");
    expect_stat(16'h0001, 16'h0000, "R8 pin ignored");
    bus_wr(2'd0, 16'h8000);
    send(8'h77, 0, 0, 1, 1);
    expect_stat(16'h0001, 16'h0000, "R8 loop ignored");

    // R9 idle flag
    fork
      send(8'h3C, 0, 0, 1, 0);
      begin
        repeat (bp * 4) @(negedge clk);
        expect_stat(16'h0010, 16'h0000, "R9 busy mid-frame");
      end
    join
    expect_stat(16'h0010, 16'h0010, "R9 idle after");
    expect_byte(8'h3C, "R9 data");

    // R10 short glitch rejected
    rx_pin = 1'b0;
    repeat (4) @(negedge clk);
    rx_pin = 1'b1;
    repeat (bp * 2) @(negedge clk);
    expect_stat(16'h0011, 16'h0010, "R10 glitch rejected");
    send(8'h81, 0, 0, 1, 0);
    expect_byte(8'h81, "R10 real frame");
    expect_stat(16'h0001, 16'h0000, "R10 one byte");

    // R11 disabled receiver
    bus_wr(2'd1, 16'h0000);
    send(8'h12, 0, 0, 1, 0);
    bus_wr(2'd1, 16'h1000);
    expect_stat(16'h0001, 16'h0000, "R11 rxen off");
    bus_wr(2'd0, 16'h0000);
    send(8'h13, 0, 0, 1, 0);
    expect_stat(16'h0001, 16'h0000, "R11 on off");
    bus_wr(2'd0, 16'h8000);

    // R12 divisor
    bus_wr(2'd3, 16'h0002);
    bus_rd(2'd3, d); chk(d == 16'h0002, "R12 divisor readback", d, 2);
    bp = 48;
    send(8'hA5, 0, 0, 1, 0);
    expect_byte(8'hA5, "R12 slow data");
    send(8'h5C, 2, 0, 1, 0);
    bus_wr(2'd0, 16'h8004);
    bp = 48;
    send(8'h5C, 2, 0, 1, 0);
    bus_rd(2'd2, d);
    bus_rd(2'd2, d);
    chk(d == 16'h005C, "R12 slow odd parity", d, 16'h005C);
    expect_stat(16'h0001, 16'h0000, "R12 drained");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule